// File: doc/BRIEF.md
# Retriggerable Mute Timer with Deglitch

This block turns a digital supply-detector level into a timed mute request. The raw detector level is first synchronized and then debounced. A new level is accepted only after it has held steady for a programmable number of clock cycles. Every accepted change, in either direction, starts a mute interval.

The length of the interval is not set by the system clock. It is measured by counting level changes of an external slow timing oscillator, which models a capacitor charging and discharging between two thresholds. Another accepted detector change during an interval clears the count, so the mute lasts longer. The mute request is an enable for an open-drain pull-down. A busy flag mirrors the interval so that its length can be measured.

The block has no thermal input. Thermal-shutdown events therefore cannot alter the mute request or the count.

Top module: `supply_mute_timer`

## Requirements
- R1: Every accepted change of the filtered level, rising or falling, sets `mutePullEn` to 1 on the same clock edge that updates `cmpFiltered`.
- R2: The oscillator input passes through 2 synchronizer flops and an edge detector. Both of its edges count. An oscillator change that is driven before edge E1 is counted at edge E3. The interval ends at the edge that counts the 10th transition.
- R3: An accepted level change while muting clears the transition count to 0. Exactly 10 further transitions are then needed to end the mute, whatever the count was before.
- R4: The raw level passes through 2 synchronizer flops. It is accepted only after `DEGLITCH_CYCLES` consecutive samples that differ from the filtered level. A raw change driven before edge E1 therefore shows on `cmpFiltered` after edge E(`DEGLITCH_CYCLES`+2). Pulses shorter than `DEGLITCH_CYCLES` cycles leave `cmpFiltered` unchanged and never set mute.
- R5: `mutePullEn` is an open-drain enable: 1 means pull the line low, and 0 means release it. It is 0 whenever no interval is running.
- R6: During reset, `cmpFiltered` loads the current raw level. After reset, mute is released, the count is zero, and no mute starts because of the level present at reset.
- R7: If an accepted level change and the 10th counted transition fall on the same edge, the restart wins. Mute stays at 1 and the count returns to 0.
- R8: `busy` is 1 exactly while a mute interval is running.
- R9: Oscillator transitions that occur while no interval is running are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmpRaw | input | 1 | Raw supply-detector comparator level (asynchronous) |
| oscLevel | input | 1 | Timing-oscillator level (asynchronous) |
| mutePullEn | output | 1 | 1 = drive the mute line low, 0 = release it |
| cmpFiltered | output | 1 | Debounced comparator level |
| busy | output | 1 | High while a mute interval runs |

## Verification
Two functions can fall on the same edge: acceptance of a debounced level change, and the count of the final oscillator transition. The bench sets this up by counting nine transitions first. It then toggles the raw level and, `DEGLITCH_CYCLES`-1 cycles later, toggles the oscillator, so that both synchronized paths reach the control on the same edge. The bench judges the result in two steps. First, mute must still be asserted right after that edge. Second, mute must survive nine more transitions and drop only on the tenth, which proves the count really restarted from zero.

// File: rtl/mute_timer_pkg.sv
package mute_timer_pkg;
  // Strobes issued by the control to the counting datapath
  typedef struct packed {
    logic restart;  // accepted level change: clear count, (re)start interval
    logic advance;  // count one oscillator transition
    logic finish;   // the counted transition was the last one
  } muteStrobes_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  // Reset preloads the chain with the live level so no false edge follows
  always_ff @(posedge clk) begin
    if (!rstN) pipe <= {STAGES{din}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/level_deglitch.sv
module level_deglitch #(
  parameter int DEGLITCH_CYCLES = 2000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawLevel,
  output logic syncLevel,
  output logic filtered,
  output logic changeNow
);
  localparam int HOLD_W = (DEGLITCH_CYCLES > 2) ? $clog2(DEGLITCH_CYCLES) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(DEGLITCH_CYCLES - 1);

  logic [HOLD_W-1:0] holdCnt;

  bit_sync #(.STAGES(SYNC_STAGES)) u_rawSync (
    .clk (clk),
    .rstN(rstN),
    .din (rawLevel),
    .dout(syncLevel)
  );

  assign changeNow = (syncLevel != filtered) && (holdCnt == HOLD_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtered <= rawLevel;
      holdCnt  <= '0;
    end else if (syncLevel == filtered) begin
      holdCnt  <= '0;
    end else if (changeNow) begin
      filtered <= syncLevel;
      holdCnt  <= '0;
    end else begin
      holdCnt  <= holdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mute_datapath.sv
module mute_datapath
  import mute_timer_pkg::*;
#(
  parameter int OSC_TRANSITIONS = 10,
  parameter int SYNC_STAGES     = 2,
  localparam int CNT_W          = $clog2(OSC_TRANSITIONS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscLevel,
  input  muteStrobes_t     strobes,
  output logic             oscEdge,
  output logic             atLastCount,
  output logic [CNT_W-1:0] transCount
);
  localparam logic [CNT_W-1:0] LAST_COUNT = CNT_W'(OSC_TRANSITIONS - 1);

  logic oscSync;
  logic oscPrev;

  bit_sync #(.STAGES(SYNC_STAGES)) u_oscSync (
    .clk (clk),
    .rstN(rstN),
    .din (oscLevel),
    .dout(oscSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) oscPrev <= oscLevel;
    else       oscPrev <= oscSync;
  end

  // Both polarities of the oscillator count as one transition
  assign oscEdge     = oscSync ^ oscPrev;
  assign atLastCount = (transCount == LAST_COUNT);

  always_ff @(posedge clk) begin
    if (!rstN)                                transCount <= '0;
    else if (strobes.restart || strobes.finish) transCount <= '0;
    else if (strobes.advance)                 transCount <= transCount + 1'b1;
  end
endmodule

// File: rtl/mute_ctrl.sv
module mute_ctrl
  import mute_timer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         levelChange,
  input  logic         oscEdge,
  input  logic         atLastCount,
  output muteStrobes_t strobes,
  output logic         muting
);
  // A level change outranks any transition counted in the same cycle
  always_comb begin
    strobes.restart = levelChange;
    strobes.advance = muting && oscEdge && !levelChange;
    strobes.finish  = muting && oscEdge && !levelChange && atLastCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               muting <= 1'b0;
    else if (strobes.restart) muting <= 1'b1;
    else if (strobes.finish)  muting <= 1'b0;
  end
endmodule

// File: rtl/supply_mute_timer.sv
module supply_mute_timer
  import mute_timer_pkg::*;
#(
  parameter int DEGLITCH_CYCLES = 2000,  // 16 us at 125 MHz
  parameter int OSC_TRANSITIONS = 10,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmpRaw,
  input  logic oscLevel,
  output logic mutePullEn,
  output logic cmpFiltered,
  output logic busy
);
  localparam int CNT_W = $clog2(OSC_TRANSITIONS);

  logic             cmpSync;
  logic             levelChange;
  logic             oscEdge;
  logic             atLastCount;
  logic             muting;
  logic [CNT_W-1:0] transCount;
  muteStrobes_t     strobes;

  level_deglitch #(
    .DEGLITCH_CYCLES(DEGLITCH_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_deglitch (
    .clk      (clk),
    .rstN     (rstN),
    .rawLevel (cmpRaw),
    .syncLevel(cmpSync),
    .filtered (cmpFiltered),
    .changeNow(levelChange)
  );

  mute_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .levelChange(levelChange),
    .oscEdge    (oscEdge),
    .atLastCount(atLastCount),
    .strobes    (strobes),
    .muting     (muting)
  );

  mute_datapath #(
    .OSC_TRANSITIONS(OSC_TRANSITIONS),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .oscLevel   (oscLevel),
    .strobes    (strobes),
    .oscEdge    (oscEdge),
    .atLastCount(atLastCount),
    .transCount (transCount)
  );

  assign mutePullEn = muting;
  assign busy       = muting;
endmodule

// File: rtl/mute_timer_checker.sv
module mute_timer_checker #(
  parameter int OSC_TRANSITIONS = 10,
  localparam int CNT_W          = $clog2(OSC_TRANSITIONS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             mutePullEn,
  input logic             cmpFiltered,
  input logic             cmpSync,
  input logic             levelChange,
  input logic             oscEdge,
  input logic [CNT_W-1:0] transCount
);
  assert_mute_on_change_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFiltered != $past(cmpFiltered)) |-> mutePullEn);

  assert_release_on_osc_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mutePullEn) |-> $past(oscEdge));

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    int'(transCount) < OSC_TRANSITIONS);

  assert_accept_sync_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFiltered != $past(cmpFiltered)) |-> ($past(cmpSync) == cmpFiltered));

  assert_idle_count_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !mutePullEn |-> (transCount == '0));

  assert_restart_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(levelChange) |-> (mutePullEn && transCount == '0));
endmodule

bind supply_mute_timer mute_timer_checker #(.OSC_TRANSITIONS(OSC_TRANSITIONS)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .mutePullEn (mutePullEn),
  .cmpFiltered(cmpFiltered),
  .cmpSync    (cmpSync),
  .levelChange(levelChange),
  .oscEdge    (oscEdge),
  .transCount (transCount)
);

// File: tb/supply_mute_timer_bench.sv
module supply_mute_timer_bench;
  localparam int DG = 4;
  localparam int NT = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpRaw = 1'b1;
  logic oscLevel = 1'b0;
  logic mutePullEn, cmpFiltered, busy;
  int   compared = 0;
  int   mismatched = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  supply_mute_timer #(.DEGLITCH_CYCLES(DG), .OSC_TRANSITIONS(NT)) u_supply_mute_timer (
    .clk(clk), .rstN(rstN), .cmpRaw(cmpRaw), .oscLevel(oscLevel),
    .mutePullEn(mutePullEn), .cmpFiltered(cmpFiltered), .busy(busy)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One oscillator transition, spaced so each is counted separately
  task automatic toggleOsc();
    oscLevel = ~oscLevel;
    waitNeg(4);
  endtask

  // Step the raw level and check the exact acceptance edge
  task automatic stepRaw(input string req);
    logic oldLvl;
    oldLvl = cmpFiltered;
    cmpRaw = ~cmpRaw;
    waitNeg(DG + 1);
    check({req, " R4 filtered before accept"}, cmpFiltered, oldLvl);
    waitNeg(1);
    check({req, " R4 filtered after accept"}, cmpFiltered, ~oldLvl);
    check({req, " R1 mute on change"}, mutePullEn, 1'b1);
  endtask

  // Exactly NT transitions end the interval, released at E3 after the last
  task automatic expectRelease(input string req);
    for (int i = 0; i < NT - 1; i++) toggleOsc();
    check({req, " R3 still muted after NT-1"}, mutePullEn, 1'b1);
    check({req, " R8 busy during interval"}, busy, 1'b1);
    oscLevel = ~oscLevel;
    waitNeg(2);
    check({req, " R2 muted before count edge"}, mutePullEn, 1'b1);
    waitNeg(1);
    check({req, " R2 released at last count"}, mutePullEn, 1'b0);
    check({req, " R8 busy cleared"}, busy, 1'b0);
    waitNeg(2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(DG + 4);
    // R6: reset loads raw level, no mute
    check("R6 filtered loads raw", cmpFiltered, 1'b1);
    check("R6 mute released", mutePullEn, 1'b0);
    check("R5 line released when idle", mutePullEn, 1'b0);
    check("R8 busy idle", busy, 1'b0);

    // R9: transitions while idle are not counted
    for (int i = 0; i < 5; i++) toggleOsc();
    check("R9 idle osc no mute", mutePullEn, 1'b0);
    stepRaw("R9");
    expectRelease("R9");

    // R4: pulse-width sweep, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int w = 1; w <= DG + 2; w++) begin
        logic orig;
        orig = cmpFiltered;
        cmpRaw = ~cmpRaw;
        waitNeg(w);
        cmpRaw = ~cmpRaw;
        waitNeg(DG + 4);
        check("R4 filtered after pulse", cmpFiltered, orig);
        if (w < DG) begin
          check("R4 short pulse ignored", mutePullEn, 1'b0);
        end else begin
          check("R1 both changes mute", mutePullEn, 1'b1);
          expectRelease("R1");
        end
      end
      stepRaw("R1 polarity flip");
      expectRelease("R1 polarity flip");
    end

    // R3: retrigger after every count position
    for (int k = 0; k < NT; k++) begin
      stepRaw("R3 start");
      for (int j = 0; j < k; j++) toggleOsc();
      check("R3 muted before retrigger", mutePullEn, 1'b1);
      stepRaw("R3 retrigger");
      expectRelease("R3");
    end

    // R7: level change and last count on the same edge
    stepRaw("R7 start");
    for (int j = 0; j < NT - 1; j++) toggleOsc();
    cmpRaw = ~cmpRaw;
    waitNeg(DG - 1);
    oscLevel = ~oscLevel;
    waitNeg(3);
    check("R7 restart wins, mute held", mutePullEn, 1'b1);
    expectRelease("R7");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule